// File: doc/BRIEF.md
# Paired-Ones Code Checker

This block decides whether a serial code word obeys a pairing rule: every one in the word must sit in a run of exactly two adjacent ones. A lone one is a violation, and so is a run of three or more ones. Word length is not fixed. The checker therefore consumes one bit per clock and carries a 2-bit stage state from bit to bit. A sticky error output rises on the first violation and stays high until the next word begins.

Each bit arrives with a valid strobe. Start-of-word and end-of-word markers frame the word, and both may share a cycle with a data bit. One cycle after the end marker, a verdict strobe shows that the error output holds the verdict for the whole word.

A second, purely combinational form checks a fixed-width word in one step. It builds the word check from a cascade of identical unit cells, one per bit. Each cell passes the same 2-bit stage code to the next cell, and bit 0 is the first bit in time.

The stage code has four states:

- `ST_IDLE` = 00: no run is open.
- `ST_ONE` = 01: one one has been seen.
- `ST_TWO` = 10: a pair is complete.
- `ST_ERR` = 11: a violation has been seen. This state absorbs.

The transitions are:

- IDLE on 0 stays in IDLE; IDLE on 1 goes to ONE.
- ONE on 1 goes to TWO; ONE on 0 goes to ERR.
- TWO on 0 goes to IDLE; TWO on 1 goes to ERR.
- ERR stays in ERR on any bit.
- The end of a word in ONE goes to ERR.
- A start of word goes to IDLE before the bit of the same cycle is applied.

Top module: `pair_code_checker`

## Requirements
- R1: A word in which every run of ones has length exactly two ends with `err_z` low at the verdict.
- R2: A one followed by a zero in the stage state ONE (a lone one) drives the state to ERR, so `err_z` is high on the next cycle.
- R3: A one arriving in state TWO (a run of three or more ones) drives the state to ERR, so `err_z` is high on the next cycle.
- R4: In state IDLE a valid zero leaves the state IDLE, and an all-zero word gives a verdict with `err_z` low.
- R5: Once `err_z` is high it stays high until a cycle with `word_start`, whatever bits follow.
- R6: `word_start` returns the state to IDLE and clears `err_z`. A bit presented in the same cycle is taken as the first bit of the new word. This also holds when `word_end` falls in that same cycle, giving a one-bit word. A start in the middle of a word abandons the old word.
- R7: In a cycle with `bit_valid`, `word_start` and `word_end` all low, the state does not change.
- R8: `word_end` seen while the state, after any bit of that cycle, is ONE gives an error. A word ending in "11" is accepted.
- R9: `verdict_valid` pulses high for exactly the cycle after `word_end`, and `err_z` then carries the word's verdict. After reset, `err_z` and `verdict_valid` are low.
- R10: `par_z` is high exactly when the `PAR_BITS`-wide word `par_word` breaks the rule, with `par_word[0]` as the first bit. It matches the serial verdict for the same bit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | `bit_data` holds a code bit this cycle |
| bit_data | input | 1 | Serial code bit |
| word_start | input | 1 | First cycle of a new word |
| word_end | input | 1 | Last cycle of the current word |
| err_z | output | 1 | Sticky error flag of the current word |
| verdict_valid | output | 1 | One-cycle strobe after `word_end` |
| par_word | input | PAR_BITS | Word for the combinational cascade, bit 0 first |
| par_z | output | 1 | Combinational error flag of `par_word` |

## Verification
The start-of-word reset, the bit step and the end-of-word check can all land in the same cycle. The bench provokes this with one-bit words, where start, valid and end are raised together with data 1 and then with data 0. It also provokes it by restarting in the middle of a word that has an open single one. In each case the bench judges the result only at the verdict strobe, against a run-length scan of the new word alone, so any state leaking from the old word shows up as a mismatch. Constrained random words with random idle gaps are checked the same way. The same words are applied to the cascade and compared with the same scan.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_ERR  = 2'b11
    } pair_state_t;

    // One step of the pairing rule for one code bit.
    function automatic pair_state_t pair_step(input pair_state_t cur, input logic d);
        pair_state_t nxt;
        unique case (cur)
            ST_IDLE: nxt = d ? ST_ONE : ST_IDLE;
            ST_ONE:  nxt = d ? ST_TWO : ST_ERR;
            ST_TWO:  nxt = d ? ST_ERR : ST_IDLE;
            ST_ERR:  nxt = ST_ERR;
            default: nxt = ST_ERR;
        endcase
        return nxt;
    endfunction

    // A word may not close with a run that is still open at a single one.
    function automatic pair_state_t pair_close(input pair_state_t cur);
        return (cur == ST_ONE) ? ST_ERR : cur;
    endfunction

endpackage

// File: rtl/pair_cell.sv
module pair_cell
    import pair_pkg::*;
(
    input  pair_state_t s_in,
    input  logic        d,
    output pair_state_t s_out
);

    always_comb begin
        s_out = pair_step(s_in, d);
    end

endmodule

// File: rtl/pair_cascade.sv
module pair_cascade
    import pair_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] word,
    output logic         z
);

    pair_state_t stg [0:N];

    assign stg[0] = ST_IDLE;

    for (genvar i = 0; i < N; i++) begin : g_cell
        pair_cell u_cell (
            .s_in  (stg[i]),
            .d     (word[i]),
            .s_out (stg[i+1])
        );
    end

    assign z = (pair_close(stg[N]) == ST_ERR);

endmodule

// File: rtl/pair_serial.sv
module pair_serial
    import pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic word_start,
    input  logic word_end,
    output logic err_z
);

    pair_state_t st_q, st_d;

    // Next state: start resets, then the bit steps, then the end check.
    always_comb begin
        st_d = st_q;
        if (word_start) st_d = ST_IDLE;
        if (bit_valid)  st_d = pair_step(st_d, bit_data);
        if (word_end)   st_d = pair_close(st_d);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        err_z = (st_q == ST_ERR);
    end

    assert_lone_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ONE && bit_valid && !bit_data && !word_start) |=> err_z);

    assert_triple_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TWO && bit_valid && bit_data && !word_start) |=> err_z);

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && bit_valid && !bit_data && !word_start && !word_end)
        |=> (st_q == ST_IDLE));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_z && !word_start) |=> err_z);

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !(bit_valid && bit_data)) |=> !err_z);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !word_start && !word_end) |=> $stable(st_q));

    assert_open_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ONE && !bit_valid && word_end && !word_start) |=> err_z);

endmodule

// File: rtl/pair_code_checker.sv
module pair_code_checker
    import pair_pkg::*;
#(
    parameter int PAR_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_valid,
    input  logic                bit_data,
    input  logic                word_start,
    input  logic                word_end,
    output logic                err_z,
    output logic                verdict_valid,
    input  logic [PAR_BITS-1:0] par_word,
    output logic                par_z
);

    logic verdict_q;

    pair_serial u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .word_start (word_start),
        .word_end   (word_end),
        .err_z      (err_z)
    );

    pair_cascade #(.N(PAR_BITS)) u_cascade (
        .word (par_word),
        .z    (par_z)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) verdict_q <= 1'b0;
        else        verdict_q <= word_end;
    end

    assign verdict_valid = verdict_q;

    assert_verdict_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> verdict_valid);

    assert_verdict_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !word_end |=> !verdict_valid);

endmodule

// File: tb/pair_code_checker_tb_top.sv
module pair_code_checker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0, bit_data = 1'b0, word_start = 1'b0, word_end = 1'b0;
    logic err_z, verdict_valid, par_z;
    logic [PW-1:0] par_word = '0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_code_checker #(.PAR_BITS(PW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_valid     (bit_valid),
        .bit_data      (bit_data),
        .word_start    (word_start),
        .word_end      (word_end),
        .err_z         (err_z),
        .verdict_valid (verdict_valid),
        .par_word      (par_word),
        .par_z         (par_z)
    );

    // Reference: scan run lengths; any run of ones other than two is an error.
    function automatic logic ref_bad(input logic [63:0] w, input int len);
        int run = 0;
        logic bad = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (w[i]) run++;
            else begin
                if (run != 0 && run != 2) bad = 1'b1;
                run = 0;
            end
        end
        if (run != 0 && run != 2) bad = 1'b1;
        return bad;
    endfunction

    function automatic logic [63:0] str_bits(input string s);
        logic [63:0] w = '0;
        for (int i = 0; i < s.len(); i++) w[i] = (s[i] == "1");
        return w;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bit_valid = 1'b0; bit_data = 1'b0; word_start = 1'b0; word_end = 1'b0;
    endtask

    // Serial word, bit 0 first; optional idle gaps between bits.
    task automatic run_word(input logic [63:0] w, input int len, input string req, input bit gaps);
        for (int k = 0; k < len; k++) begin
            if (gaps && k > 0 && ($urandom % 3 == 0)) begin
                idle_inputs();
                @(negedge clk);
            end
            bit_valid = 1'b1; bit_data = w[k];
            word_start = (k == 0); word_end = (k == len - 1);
            @(negedge clk);
        end
        idle_inputs();
        check({req, " verdict strobe"}, verdict_valid, 1'b1);
        check({req, " verdict"}, err_z, ref_bad(w, len));
        @(negedge clk);
        check({req, " strobe drop"}, verdict_valid, 1'b0);
    endtask

    task automatic run_par(input logic [63:0] w, input string req);
        par_word = w[PW-1:0];
        #1;
        check(req, par_z, ref_bad(w, PW));
    endtask

    task automatic directed(input string s, input string req, input bit gaps);
        run_word(str_bits(s), s.len(), req, gaps);
        run_par(str_bits(s), {req, " R10 cascade"});
    endtask

    initial begin
        void'($urandom(32'h0BADC0DE));
        repeat (3) @(negedge clk);
        check("R9 reset err_z", err_z, 1'b0);
        check("R9 reset strobe", verdict_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        directed("0000000000", "R4 all zero", 1'b0);
        directed("0110110", "R1 pairs", 1'b0);
        directed("00011", "R8 ends in 11", 1'b0);
        directed("0001", "R8 ends in single one", 1'b0);
        directed("01000", "R2 lone one", 1'b0);
        directed("011100", "R3 triple", 1'b0);
        directed("1001100110", "R5 sticky", 1'b0);
        directed("0110", "R7 gaps", 1'b1);
        directed("1", "R6 one-bit one", 1'b0);
        directed("0", "R6 one-bit zero", 1'b0);

        // R6: restart while a single one is still open.
        bit_valid = 1'b1; bit_data = 1'b1; word_start = 1'b1; word_end = 1'b0;
        @(negedge clk);
        run_word(str_bits("0110"), 4, "R6 restart mid-word", 1'b0);

        // R5: error word, then clean bits with no start keep the flag.
        run_word(str_bits("010"), 3, "R5 error word", 1'b0);
        bit_valid = 1'b1; bit_data = 1'b0;
        @(negedge clk);
        idle_inputs();
        check("R5 flag held without start", err_z, 1'b1);

        // Random words, serial and cascade.
        for (int n = 0; n < 300; n++) begin
            logic [63:0] w = '0;
            int len = 0;
            int target = 1 + ($urandom % 24);
            while (len < target) begin
                int r = $urandom % 6;
                if (r < 3) begin w[len] = 1'b0; len++; end
                else if (r < 5) begin w[len] = 1'b1; w[len+1] = 1'b1; len += 2; end
                else if ($urandom % 2 == 0) begin w[len] = 1'b1; len++; end
                else begin w[len] = 1'b1; w[len+1] = 1'b1; w[len+2] = 1'b1; len += 3; end
            end
            if (len > 24) len = 24;
            for (int b = len; b < 64; b++) w[b] = 1'b0;
            run_word(w, len, "R1 random", bit'($urandom % 2));
            run_par(w, "R10 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule